// File: doc/BRIEF.md
# Half-width brain-float immediate to double-precision expander

This block executes a floating-point load-immediate operation in a single combinational step. It receives one 32-bit instruction word together with a valid strobe. From that word it recovers a 16-bit brain-float immediate whose sign bit sits in the final instruction bit and whose other fifteen bits sit in a middle field. It pads the immediate with sixteen zero bits to form a single-precision pattern. It then widens that pattern exactly into an IEEE754 double. Subnormal single values are normalised, so the double equals the single value bit for bit.

The block drives the double, the destination register number and a write strobe toward a floating-point register file. The write strobe is raised only for a valid word that carries the configured major and extended opcodes. No rounding is involved. The block has no flag or condition output.

Top module: `bf16x_imm_expand`

## Requirements
- R1: Instruction bits are numbered 0 (most significant, LSB-0 bit 31) to 31. The immediate is formed with instruction bit 31 (LSB-0 bit 0) as bit 15 and instruction bits 11..25 (LSB-0 bits 20..6) as bits 14..0. The result sign equals immediate bit 15.
- R2: `dest_o` equals instruction bits 6..10 (LSB-0 bits 25..21). `dest_o` and `result_o` follow the instruction word whether or not the write strobe is raised.
- R3: `wr_en_o` is 1 only when `valid_i` is 1, instruction bits 0..5 (LSB-0 31..26) equal `MAJOR_OP` and bits 26..30 (LSB-0 5..1) equal `EXT_OP`. Otherwise it is 0.
- R4: Immediates 0x0000 and 0x8000 give the doubles +0.0 (0x0000000000000000) and -0.0 (0x8000000000000000).
- R5: Normal immediates are widened exactly. 0x3F80 gives +1.0, 0xBF80 gives -1.0, 0xBFC0 gives -1.5 and 0x3FFF gives +1.9921875. The exponent is re-biased from 127 to 1023 and the fraction is left-aligned in 52 bits.
- R6: An all-ones single exponent gives an all-ones double exponent with the fraction kept. 0x7F80 gives +infinity, 0xFF80 gives -infinity and 0x7FC0 gives the positive quiet NaN 0x7FF8000000000000.
- R7: Subnormal immediates (exponent field zero, fraction non-zero) give the exact normalised double. For example, 0x0040 gives 0x3800000000000000 and 0x0001 gives 0x37A0000000000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 32 | Instruction word |
| valid_i | input | 1 | Instruction word is valid this cycle |
| dest_o | output | 5 | Destination floating-point register number |
| result_o | output | 64 | Double-precision value to write |
| wr_en_o | output | 1 | Register write strobe |

## Verification
Two things happen in the same evaluation: the strobe qualification and the value widening, including subnormal normalisation. The bench provokes both together by sending words that carry a subnormal, NaN or infinity immediate, while either the valid strobe is low or one opcode field is off by a single bit. It judges each case by checking that the strobe is low while `dest_o` and `result_o` still hold the exact widened value. It then re-sends the same immediate with a matching word and expects the strobe high with an identical result.

// File: rtl/bf16x_pkg.sv
package bf16x_pkg;
   localparam int INSN_W     = 32;
   localparam int IMM_W      = 16;
   localparam int MAJ_LSB    = 26;
   localparam int MAJ_W      = 6;
   localparam int DST_LSB    = 21;
   localparam int DST_W      = 5;
   localparam int IMM_LO_LSB = 6;
   localparam int IMM_LO_W   = 15;
   localparam int XO_LSB     = 1;
   localparam int XO_W       = 5;
   localparam int IMM_HI_BIT = 0;

   typedef struct packed {
      logic [MAJ_W-1:0] major;
      logic [DST_W-1:0] dest;
      logic [IMM_W-1:0] imm;
      logic [XO_W-1:0]  xop;
   } insn_fields_t;
endpackage

// File: rtl/bf16x_field_split.sv
module bf16x_field_split
   import bf16x_pkg::*;
#(
   parameter logic [MAJ_W-1:0] MAJOR_OP = 6'd19,
   parameter logic [XO_W-1:0]  EXT_OP   = 5'd3
) (
   input  logic [INSN_W-1:0] insn_i,
   input  logic              valid_i,
   output insn_fields_t      fields_o,
   output logic              hit_o
);
   always_comb begin
      fields_o.major = insn_i[MAJ_LSB +: MAJ_W];
      fields_o.dest  = insn_i[DST_LSB +: DST_W];
      fields_o.xop   = insn_i[XO_LSB +: XO_W];
      fields_o.imm   = {insn_i[IMM_HI_BIT], insn_i[IMM_LO_LSB +: IMM_LO_W]};
   end

   assign hit_o = valid_i && (fields_o.major == MAJOR_OP) && (fields_o.xop == EXT_OP);
endmodule

// File: rtl/bf16x_lzc.sv
module bf16x_lzc #(
   parameter int W        = 23,
   parameter bit USE_TREE = 1'b1,
   localparam int CW      = $clog2(W + 1),
   localparam int P       = 1 << CW
) (
   input  logic [W-1:0]  data_i,
   output logic [CW-1:0] count_o
);
   generate
      if (USE_TREE) begin : g_tree
         logic [P-1:0] padded;
         assign padded = {data_i, {(P-W){1'b1}}};
         always_comb begin
            logic [P-1:0] x;
            x       = padded;
            count_o = '0;
            for (int s = CW - 1; s >= 0; s--) begin
               if ((x >> (P - (1 << s))) == '0) begin
                  count_o[s] = 1'b1;
                  x          = x << (1 << s);
               end
            end
         end
      end else begin : g_scan
         always_comb begin
            count_o = CW'(W);
            for (int i = 0; i < W; i++) begin
               if (data_i[i]) count_o = CW'(W - 1 - i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/bf16x_sp2dp.sv
module bf16x_sp2dp #(
   parameter int SP_EXP_W  = 8,
   parameter int SP_FRAC_W = 23,
   parameter int DP_EXP_W  = 11,
   parameter int DP_FRAC_W = 52,
   parameter bit LZC_TREE  = 1'b1,
   localparam int SP_W     = 1 + SP_EXP_W + SP_FRAC_W,
   localparam int DP_W     = 1 + DP_EXP_W + DP_FRAC_W
) (
   input  logic [SP_W-1:0] sp_i,
   output logic [DP_W-1:0] dp_o
);
   localparam int SP_BIAS = (1 << (SP_EXP_W - 1)) - 1;
   localparam int DP_BIAS = (1 << (DP_EXP_W - 1)) - 1;
   localparam int BIAS_D  = DP_BIAS - SP_BIAS;
   localparam int LZ_W    = $clog2(SP_FRAC_W + 1);
   localparam int PAD_W   = DP_FRAC_W - SP_FRAC_W;

   logic                 sgn;
   logic [SP_EXP_W-1:0]  sexp;
   logic [SP_FRAC_W-1:0] sfrac;
   logic [LZ_W-1:0]      lz;
   logic [LZ_W:0]        shamt;
   logic [SP_FRAC_W-1:0] nfrac;
   logic [DP_EXP_W-1:0]  dexp;
   logic [SP_FRAC_W-1:0] dfrac_hi;

   assign {sgn, sexp, sfrac} = sp_i;

   bf16x_lzc #(.W(SP_FRAC_W), .USE_TREE(LZC_TREE)) lzc_i (
      .data_i  (sfrac),
      .count_o (lz)
   );

   assign shamt = {1'b0, lz} + (LZ_W+1)'(1);
   assign nfrac = sfrac << shamt;

   always_comb begin
      if (sexp == '1) begin
         dexp     = '1;
         dfrac_hi = sfrac;
      end else if (sexp == '0) begin
         if (sfrac == '0) begin
            dexp     = '0;
            dfrac_hi = '0;
         end else begin
            dexp     = DP_EXP_W'(BIAS_D) - DP_EXP_W'(lz);
            dfrac_hi = nfrac;
         end
      end else begin
         dexp     = DP_EXP_W'(sexp) + DP_EXP_W'(BIAS_D);
         dfrac_hi = sfrac;
      end
   end

   assign dp_o = {sgn, dexp, dfrac_hi, {PAD_W{1'b0}}};
endmodule

// File: rtl/bf16x_imm_expand.sv
module bf16x_imm_expand
   import bf16x_pkg::*;
#(
   parameter logic [5:0] MAJOR_OP  = 6'd19,
   parameter logic [4:0] EXT_OP    = 5'd3,
   parameter int         SP_EXP_W  = 8,
   parameter int         SP_FRAC_W = 23,
   parameter int         DP_EXP_W  = 11,
   parameter int         DP_FRAC_W = 52,
   parameter bit         LZC_TREE  = 1'b1
) (
   input  logic [31:0]                      insn_i,
   input  logic                             valid_i,
   output logic [4:0]                       dest_o,
   output logic [DP_EXP_W+DP_FRAC_W:0]      result_o,
   output logic                             wr_en_o
);
   localparam int SP_W = 1 + SP_EXP_W + SP_FRAC_W;

   if (SP_W < IMM_W) begin : g_bad_sp
      $error("single format narrower than immediate");
   end
   if (DP_EXP_W <= SP_EXP_W || DP_FRAC_W <= SP_FRAC_W) begin : g_bad_dp
      $error("double format must be wider than single format");
   end

   insn_fields_t    fld;
   logic            hit;
   logic [SP_W-1:0] sp_val;

   bf16x_field_split #(.MAJOR_OP(MAJOR_OP), .EXT_OP(EXT_OP)) split_i (
      .insn_i   (insn_i),
      .valid_i  (valid_i),
      .fields_o (fld),
      .hit_o    (hit)
   );

   if (SP_W > IMM_W) begin : g_pad
      assign sp_val = {fld.imm, {(SP_W-IMM_W){1'b0}}};
   end else begin : g_nopad
      assign sp_val = fld.imm;
   end

   bf16x_sp2dp #(
      .SP_EXP_W (SP_EXP_W), .SP_FRAC_W (SP_FRAC_W),
      .DP_EXP_W (DP_EXP_W), .DP_FRAC_W (DP_FRAC_W),
      .LZC_TREE (LZC_TREE)
   ) widen_i (
      .sp_i (sp_val),
      .dp_o (result_o)
   );

   assign dest_o  = fld.dest;
   assign wr_en_o = hit;
endmodule

// File: rtl/bf16x_imm_expand_chk.sv
module bf16x_imm_expand_chk #(
   parameter logic [5:0] MAJOR_OP = 6'd19,
   parameter logic [4:0] EXT_OP   = 5'd3
) (
   input logic [31:0] insn_i,
   input logic        valid_i,
   input logic [4:0]  dest_o,
   input logic [63:0] result_o,
   input logic        wr_en_o
);
   always_comb begin
      if (!$isunknown({insn_i, valid_i})) begin
         assert_sign_R1 : assert (result_o[63] == insn_i[0])
            else $error("sign bit does not follow last instruction bit");
         assert_dest_R2 : assert (dest_o == insn_i[25:21])
            else $error("destination mismatch");
         assert_wr_gate_R3 : assert (wr_en_o == (valid_i && insn_i[31:26] == MAJOR_OP && insn_i[5:1] == EXT_OP))
            else $error("write strobe qualification wrong");
         if (insn_i[20:6] == 15'd0) begin
            assert_zero_R4 : assert (result_o[62:0] == 63'd0)
               else $error("zero immediate did not give signed zero");
         end
         if (insn_i[20:13] == 8'hFF) begin
            assert_special_R6 : assert (result_o[62:52] == 11'h7FF && result_o[51:45] == insn_i[12:6])
               else $error("special value not preserved");
         end
         if (insn_i[20:13] == 8'h00 && insn_i[12:6] != 7'd0) begin
            assert_subnorm_R7 : assert (result_o[62:52] != 11'd0 && result_o[62:52] < 11'd897)
               else $error("subnormal exponent out of range");
         end
      end
   end
endmodule

bind bf16x_imm_expand bf16x_imm_expand_chk #(.MAJOR_OP(MAJOR_OP), .EXT_OP(EXT_OP)) chk_i (
   .insn_i   (insn_i),
   .valid_i  (valid_i),
   .dest_o   (dest_o),
   .result_o (result_o),
   .wr_en_o  (wr_en_o)
);

// File: tb/bf16x_imm_expand_tb_top.sv
module bf16x_imm_expand_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [5:0] MAJ = 6'd19;
   localparam logic [4:0] XO  = 5'd3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] insn_i = '0;
   logic        valid_i = 1'b0;
   logic [4:0]  dest_o;
   logic [63:0] result_o;
   logic        wr_en_o;
   int          n_tests = 0;
   int          n_fail  = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bf16x_imm_expand #(.MAJOR_OP(MAJ), .EXT_OP(XO)) dut_i (
      .insn_i (insn_i), .valid_i (valid_i),
      .dest_o (dest_o), .result_o (result_o), .wr_en_o (wr_en_o)
   );

   function automatic logic [31:0] mk(logic [5:0] maj, logic [4:0] dst, logic [15:0] imm, logic [4:0] xo);
      return {maj, dst, imm[14:0], xo, imm[15]};
   endfunction

   function automatic logic [63:0] ref_dp(logic [15:0] b);
      logic s = b[15];
      int   e = int'(b[14:7]);
      int   f = int'(b[6:0]);
      real  mag;
      if (e == 255) return {s, 11'h7FF, b[6:0], 45'd0};
      if (e == 0 && f == 0) return {s, 63'd0};
      if (e == 0) mag = (real'(f) / 128.0) * (2.0 ** (-126.0));
      else        mag = (1.0 + real'(f) / 128.0) * (2.0 ** (real'(e) - 127.0));
      return $realtobits(s ? -mag : mag);
   endfunction

   task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic apply(logic [31:0] w, logic v);
      @(posedge clk);
      insn_i  = w;
      valid_i = v;
      @(negedge clk);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R3 idle strobe", 64'(wr_en_o), 64'd0);
   endtask

   task automatic t_constants;
      apply(mk(MAJ, 5'd4, 16'h0000, XO), 1'b1);
      chk("R4 +0.0", result_o, 64'h0000000000000000);
      chk("R3 strobe on match", 64'(wr_en_o), 64'd1);
      apply(mk(MAJ, 5'd4, 16'h8000, XO), 1'b1);
      chk("R4 -0.0", result_o, 64'h8000000000000000);
      chk("R1 sign from last bit", 64'(result_o[63]), 64'd1);
      apply(mk(MAJ, 5'd4, 16'h3F80, XO), 1'b1);
      chk("R5 +1.0", result_o, 64'h3FF0000000000000);
      apply(mk(MAJ, 5'd4, 16'hBF80, XO), 1'b1);
      chk("R5 -1.0", result_o, 64'hBFF0000000000000);
      apply(mk(MAJ, 5'd4, 16'hBFC0, XO), 1'b1);
      chk("R5 -1.5", result_o, 64'hBFF8000000000000);
      apply(mk(MAJ, 5'd4, 16'h3FFF, XO), 1'b1);
      chk("R5 +1.9921875", result_o, 64'h3FFFE00000000000);
      apply(mk(MAJ, 5'd4, 16'h7FC0, XO), 1'b1);
      chk("R6 +qNaN", result_o, 64'h7FF8000000000000);
      apply(mk(MAJ, 5'd4, 16'h7F80, XO), 1'b1);
      chk("R6 +inf", result_o, 64'h7FF0000000000000);
      apply(mk(MAJ, 5'd4, 16'hFF80, XO), 1'b1);
      chk("R6 -inf", result_o, 64'hFFF0000000000000);
   endtask

   task automatic t_subnormal;
      apply(mk(MAJ, 5'd9, 16'h0040, XO), 1'b1);
      chk("R7 0x0040", result_o, 64'h3800000000000000);
      apply(mk(MAJ, 5'd9, 16'h0001, XO), 1'b1);
      chk("R7 0x0001", result_o, 64'h37A0000000000000);
      apply(mk(MAJ, 5'd9, 16'h8003, XO), 1'b1);
      chk("R7 0x8003", result_o, 64'hB7B8000000000000);
   endtask

   task automatic t_fields;
      for (int d = 0; d < 32; d++) begin
         apply(mk(MAJ, 5'(d), 16'h4000 ^ 16'(d), XO), 1'b1);
         chk("R2 dest field", 64'(dest_o), 64'(d));
      end
      apply(mk(MAJ, 5'd0, 16'h8000, XO), 1'b1);
      chk("R1 top bit alone", 64'(result_o[63:62]), 64'd2);
   endtask

   task automatic t_gating;
      apply(mk(MAJ, 5'd17, 16'h0003, XO), 1'b0);
      chk("R3 no valid", 64'(wr_en_o), 64'd0);
      chk("R2 result without strobe", result_o, ref_dp(16'h0003));
      chk("R2 dest without strobe", 64'(dest_o), 64'd17);
      apply(mk(MAJ ^ 6'd1, 5'd17, 16'h7FC1, XO), 1'b1);
      chk("R3 major off", 64'(wr_en_o), 64'd0);
      chk("R6 NaN without strobe", result_o, ref_dp(16'h7FC1));
      apply(mk(MAJ, 5'd17, 16'hFF80, XO ^ 5'd16), 1'b1);
      chk("R3 ext off", 64'(wr_en_o), 64'd0);
      chk("R6 -inf without strobe", result_o, 64'hFFF0000000000000);
      apply(mk(MAJ, 5'd17, 16'h0003, XO), 1'b1);
      chk("R3 strobe back", 64'(wr_en_o), 64'd1);
      chk("R7 same value with strobe", result_o, ref_dp(16'h0003));
   endtask

   task automatic t_sweep;
      for (int i = 0; i < 65536; i++) begin
         apply(mk(MAJ, 5'(i), 16'(i), XO), 1'b1);
         chk("R5 R6 R7 sweep", result_o, ref_dp(16'(i)));
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset;
      rst_n = 1'b1;
      t_constants;
      t_subnormal;
      t_fields;
      t_gating;
      t_sweep;
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 150000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule